// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit turns the packed odd partial remainders of a BCH codeword into the complete list of 2t syndromes that a locator solver needs. Each partial value is a 16-bit field inside a 32-bit remainder word. For every odd syndrome the unit walks the partial value one bit per cycle. For each set bit it adds a power of the primitive element into an accumulator. Each even syndrome is then produced by squaring a syndrome already computed, which is the log-domain doubling rule done without tables.

The field is chosen per operation. The 512-byte sector mode works in GF(2^13) and the 1024-byte mode in GF(2^14). A strength index selects t. The parameter `MAX_T` caps the storage, and any larger request is clamped to it. The caller pulses `start` with the field, strength and remainder words. The result appears on a flat syndrome bus, and `done` pulses once when the last entry has been written.

Top module: `bchx_syndrome_expand`

## Requirements
- R1: `wide_sel`=0 selects GF(2^13) with reduction polynomial 0x201B; `wide_sel`=1 selects GF(2^14) with reduction polynomial 0x4443. Field elements are polynomial-basis vectors in which bit k is the coefficient of x^k, and alpha = x (value 2).
- R2: `str_idx` values 0,1,2,3,4,5 request t = 2,4,8,12,24,32. The effective t is the smaller of the requested value and `MAX_T`.
- R3: The partial value of odd syndrome S(2i+1), for i = 0..t-1, is bits [16i+15:16i] of `rem_words`. This is the low half of 32-bit word i/2 when i is even and the high half when i is odd.
- R4: S(2i+1) is the XOR, over each set bit j below m of its partial value, of alpha^((2i+1)·j mod (2^m−1)). Partial bits m..15 have no effect.
- R5: For j = 1..t, S(2j) equals alpha^(2·log S(j) mod (2^m−1)), which is S(j) squared. It is zero when S(j) is zero.
- R6: `syn_bus` bits [14k−1:14(k−1)] hold S(k). In GF(2^13) the top bit of every entry is 0. Entries above 2t read as zero.
- R7: The field, strength and remainder words are captured on the edge that accepts `start`. Later changes to them do not affect the running operation.
- R8: A `start` pulse is ignored from the accepting edge through the cycle in which `done` is high.
- R9: `done` is high for exactly one cycle. It rises t·m + t clock edges after the accepting edge: odd syndromes are computed in ascending order first, then even syndromes in ascending order.
- R10: Reset clears `syn_bus` to zero and holds `done` low. After `done`, the syndromes hold until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an expansion (accepted only when idle) |
| wide_sel | input | 1 | 0: GF(2^13) / 512-byte sector, 1: GF(2^14) / 1024-byte sector |
| str_idx | input | 3 | Strength index (0..5) |
| rem_words | input | 32·ceil(MAX_T/2) | Packed partial remainder words |
| syn_bus | output | 28·MAX_T | Syndromes S(1)..S(2·MAX_T), 14 bits each |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check the following:
- `done` is a single-cycle pulse, and the phases are mutually exclusive.
- The bit walk stays below m.
- The running power of alpha never becomes zero.
- A squared entry is zero exactly when its source is zero.
- No GF(2^13) result carries bit 13.
- The bus is frozen while idle.

Only the bench scenarios can show the rest. These are the actual syndrome values in both fields against an independent log/antilog model, strength clamping, the half-word selection, and clearing of stale upper entries. They also cover the exact completion latency, and that inputs changed or `start` pulsed mid-operation leave the result untouched.

// File: rtl/bchx_pkg.sv
package bchx_pkg;
  localparam int FW = 14;
  localparam int BW = 4;

  typedef logic [FW-1:0] gf_t;
  typedef enum logic [1:0] {PH_IDLE, PH_ODD, PH_EVEN, PH_FIN} phase_e;

  // multiply by alpha with reduction in the selected field
  function automatic gf_t gf_xtime(gf_t x, logic wide);
    logic [FW:0] t;
    t = {x, 1'b0};
    if (wide) begin
      if (t[14]) t = t ^ 15'h4443;
    end else begin
      if (t[13]) t = t ^ 15'h201B;
    end
    return t[FW-1:0];
  endfunction

  // shift-and-add field multiply
  function automatic gf_t gf_mul(gf_t a, gf_t b, logic wide);
    gf_t r;
    r = '0;
    for (int k = FW-1; k >= 0; k--) begin
      r = gf_xtime(r, wide);
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [5:0] t_of_index(logic [2:0] idx);
    case (idx)
      3'd0:    return 6'd2;
      3'd1:    return 6'd4;
      3'd2:    return 6'd8;
      3'd3:    return 6'd12;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [BW-1:0] last_bit(logic wide);
    return wide ? BW'(13) : BW'(12);
  endfunction
endpackage

// File: rtl/bchx_ctrl.sv
module bchx_ctrl
  import bchx_pkg::*;
#(
  parameter int MAX_T = 8,
  localparam int IW = $clog2(2*MAX_T+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wide_in,
  input  logic [2:0]    str_idx,
  output logic          accept,
  output logic          busy,
  output logic          wide_q,
  output logic          odd_step,
  output logic          syn_end,
  output logic          even_step,
  output logic          done,
  output logic [BW-1:0] bit_idx,
  output logic [IW-1:0] odd_i,
  output logic [IW-1:0] even_k
);
  phase_e        ph_q;
  logic [IW-1:0] t_q;
  logic [5:0]    t_req;
  logic [IW-1:0] t_sel;
  logic          bit_last;

  always_comb begin
    t_req = t_of_index(str_idx);
    t_sel = (int'(t_req) > MAX_T) ? IW'(MAX_T) : IW'(t_req);
  end

  assign bit_last  = (bit_idx == last_bit(wide_q));
  assign accept    = (ph_q == PH_IDLE) && start;
  assign busy      = (ph_q != PH_IDLE);
  assign odd_step  = (ph_q == PH_ODD);
  assign syn_end   = odd_step && bit_last;
  assign even_step = (ph_q == PH_EVEN);
  assign done      = (ph_q == PH_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      t_q     <= IW'(2);
      wide_q  <= 1'b0;
      bit_idx <= '0;
      odd_i   <= '0;
      even_k  <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          t_q     <= t_sel;
          wide_q  <= wide_in;
          bit_idx <= '0;
          odd_i   <= '0;
          even_k  <= IW'(1);
          ph_q    <= PH_ODD;
        end
        PH_ODD: begin
          if (bit_last) begin
            bit_idx <= '0;
            if (odd_i == t_q - 1'b1) ph_q <= PH_EVEN;
            else                     odd_i <= odd_i + 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        PH_EVEN: begin
          if (even_k == t_q) ph_q <= PH_FIN;
          else               even_k <= even_k + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  accept_to_odd_chk: assert property (@(posedge clk) disable iff (!rst_n) accept |=> odd_step);
  // R9
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({odd_step, even_step, done}));
  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n) odd_step |-> (bit_idx <= BW'(13)));
  // R2
  t_range_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (int'(t_q) >= 2 && int'(t_q) <= MAX_T));
endmodule

// File: rtl/bchx_odd_eval.sv
module bchx_odd_eval
  import bchx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic wide,
  input  logic step,
  input  logic syn_end,
  input  logic part_bit,
  output gf_t  odd_val
);
  gf_t pw_q;    // alpha^(n*j)
  gf_t acc_q;   // running XOR
  gf_t gen_q;   // alpha^n for current odd n
  gf_t acc_nx;

  always_comb acc_nx = acc_q ^ (part_bit ? pw_q : '0);
  assign odd_val = acc_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q  <= gf_t'(1);
      acc_q <= '0;
      gen_q <= gf_t'(2);
    end else if (init) begin
      pw_q  <= gf_t'(1);
      acc_q <= '0;
      gen_q <= gf_t'(2);
    end else if (step) begin
      if (syn_end) begin
        pw_q  <= gf_t'(1);
        acc_q <= '0;
        gen_q <= gf_xtime(gf_xtime(gen_q, wide), wide);
      end else begin
        acc_q <= acc_nx;
        pw_q  <= gf_mul(pw_q, gen_q, wide);
      end
    end
  end

  // R4
  pow_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) step |=> (pw_q != '0 && gen_q != '0));
endmodule

// File: rtl/bchx_syn_store.sv
module bchx_syn_store
  import bchx_pkg::*;
#(
  parameter int MAX_T = 8,
  localparam int NS = 2*MAX_T,
  localparam int IW = $clog2(2*MAX_T+1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  gf_t            wr_data,
  input  logic [IW-1:0]  rd_idx,
  output gf_t            rd_data,
  output logic [NS*FW-1:0] bus
);
  gf_t mem [NS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NS; g++) mem[g] <= '0;
    end else if (clear) begin
      for (int g = 0; g < NS; g++) mem[g] <= '0;
    end else if (wr_en) begin
      mem[wr_idx - 1'b1] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx - 1'b1];

  for (genvar g = 0; g < NS; g++) begin : g_flat
    assign bus[g*FW +: FW] = mem[g];
  end
endmodule

// File: rtl/bchx_syndrome_expand.sv
module bchx_syndrome_expand
  import bchx_pkg::*;
#(
  parameter int MAX_T = 8,
  localparam int NW = (MAX_T + 1) / 2,
  localparam int NS = 2*MAX_T,
  localparam int IW = $clog2(2*MAX_T+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wide_sel,
  input  logic [2:0]       str_idx,
  input  logic [NW*32-1:0] rem_words,
  output logic [NS*FW-1:0] syn_bus,
  output logic             done
);
  logic          accept, busy, wide_q, odd_step, syn_end, even_step;
  logic [BW-1:0] bit_idx;
  logic [IW-1:0] odd_i, even_k;
  logic [NW*32-1:0] words_q;
  logic [15:0]   part_half;
  logic          part_bit;
  gf_t           odd_val, src_val, sq_val, wr_data;
  logic          wr_en;
  logic [IW-1:0] wr_idx;

  bchx_ctrl #(.MAX_T(MAX_T)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_in(wide_sel), .str_idx(str_idx),
    .accept(accept), .busy(busy), .wide_q(wide_q), .odd_step(odd_step),
    .syn_end(syn_end), .even_step(even_step), .done(done),
    .bit_idx(bit_idx), .odd_i(odd_i), .even_k(even_k)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      words_q <= '0;
    else if (accept) words_q <= rem_words;
  end

  // half i of the packed words feeds odd syndrome 2i+1
  assign part_half = words_q[odd_i*16 +: 16];
  assign part_bit  = part_half[bit_idx];

  bchx_odd_eval u_odd (
    .clk(clk), .rst_n(rst_n), .init(accept), .wide(wide_q), .step(odd_step),
    .syn_end(syn_end), .part_bit(part_bit), .odd_val(odd_val)
  );

  assign sq_val  = gf_mul(src_val, src_val, wide_q);
  assign wr_en   = syn_end | even_step;
  assign wr_idx  = even_step ? IW'({even_k, 1'b0}) : IW'({odd_i, 1'b1});
  assign wr_data = even_step ? sq_val : odd_val;

  bchx_syn_store #(.MAX_T(MAX_T)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(accept), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(even_k), .rd_data(src_val), .bus(syn_bus)
  );

  // R5
  even_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    even_step |-> ((sq_val == '0) == (src_val == '0)));
  // R6
  narrow_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wide_q) |-> !wr_data[FW-1]);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(syn_bus));
endmodule

// File: tb/test_bchx_syndrome_expand.sv
module test_bchx_syndrome_expand;
  localparam int MAX_T = 8;
  localparam int NW = (MAX_T + 1) / 2;
  localparam int WB = NW * 32;
  localparam int SB = 2 * MAX_T * 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wide_sel = 1'b0;
  logic [2:0] str_idx = '0;
  logic [WB-1:0] rem_words = '0;
  logic [SB-1:0] syn_bus;
  logic done;

  bchx_syndrome_expand #(.MAX_T(MAX_T)) i_bchx_syndrome_expand (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_sel(wide_sel), .str_idx(str_idx),
    .rem_words(rem_words), .syn_bus(syn_bus), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  int alog [2][16384];
  int lg   [2][16384];
  logic [SB-1:0] exp_q [$];
  int            cyc_q [$];
  logic [SB-1:0] last_exp = '0;
  bit prev_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void build(int f, int m, int poly);
    int x = 1;
    int nn = (1 << m) - 1;
    for (int i = 0; i < nn; i++) begin
      alog[f][i] = x;
      lg[f][x] = i;
      x = x << 1;
      if ((x & (1 << m)) != 0) x = x ^ poly;
    end
    alog[f][nn] = 1;
    lg[f][0] = 0;
  endfunction

  function automatic int tdec(logic [2:0] idx);
    int t;
    case (idx)
      3'd0: t = 2; 3'd1: t = 4; 3'd2: t = 8; 3'd3: t = 12; 3'd4: t = 24;
      default: t = 32;
    endcase
    return (t > MAX_T) ? MAX_T : t;
  endfunction

  // log/antilog-table model of the syndrome list
  function automatic logic [SB-1:0] ref_syn(bit wide, int t, logic [WB-1:0] w);
    int f = wide ? 1 : 0;
    int m = wide ? 14 : 13;
    int nn = (1 << m) - 1;
    int s [64];
    logic [15:0] part;
    logic [SB-1:0] bus = '0;
    for (int k = 0; k < 64; k++) s[k] = 0;
    for (int i = 0; i < t; i++) begin
      int n = 2*i + 1;
      int acc = 0;
      part = w[16*i +: 16];
      for (int j = 0; j < m; j++)
        if (part[j]) acc = acc ^ alog[f][(n*j) % nn];
      s[n] = acc;
    end
    for (int j = 1; j <= t; j++)
      s[2*j] = (s[j] == 0) ? 0 : alog[f][(2*lg[f][s[j]]) % nn];
    for (int k = 1; k <= 2*t; k++) bus[14*(k-1) +: 14] = 14'(s[k]);
    return bus;
  endfunction

  // monitor: pops expectations when the design signals completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(done == 1'b0, "R9 done one cycle", 256'(done), 256'(0));
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 256'(1), 256'(0));
        end else begin
          logic [SB-1:0] e;
          int c;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          chk(syn_bus == e, "R3 R4 R5 R6 syndromes", 256'(syn_bus), 256'(e));
          chk(cyc == c, "R9 latency", 256'(cyc), 256'(c));
        end
      end
      prev_done = done;
    end
  end

  task automatic run(bit wide, logic [2:0] idx, logic [WB-1:0] w, bit disturb);
    int t = tdec(idx);
    int m = wide ? 14 : 13;
    @(negedge clk);
    wide_sel = wide; str_idx = idx; rem_words = w; start = 1'b1;
    last_exp = ref_syn(wide, t, w);
    exp_q.push_back(last_exp);
    cyc_q.push_back(cyc + 1 + t*m + t);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R7 R8: new inputs and a second start while running
      rem_words = ~w; wide_sel = ~wide; str_idx = 3'd2;
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R10: hold after completion
    chk(syn_bus == last_exp, "R10 hold after done", 256'(syn_bus), 256'(last_exp));
  endtask

  initial begin
    build(0, 13, 'h201B);
    build(1, 14, 'h4443);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(syn_bus == '0, "R10 reset bus", 256'(syn_bus), 256'(0));
    chk(done == 1'b0, "R10 reset done", 256'(done), 256'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R3 R4: narrow field, t=2
    run(1'b0, 3'd0, {$urandom, $urandom, $urandom, $urandom}, 1'b0);
    // R1: wide field, t=4
    run(1'b1, 3'd1, {$urandom, $urandom, $urandom, $urandom}, 1'b0);
    // R4: all bits set, bits >= m ignored
    run(1'b0, 3'd2, {WB{1'b1}}, 1'b0);
    // R2: index 5 clamped to MAX_T
    run(1'b1, 3'd5, {$urandom, $urandom, $urandom, $urandom}, 1'b0);
    // R5: all zero partials give all zero syndromes
    run(1'b0, 3'd3, '0, 1'b0);
    // R3 R5: single-bit halves mixed with zero halves
    run(1'b1, 3'd2, 128'h0000_0001_0000_0000_0004_0000_0000_0001, 1'b0);
    // R7 R8: disturbed run
    run(1'b0, 3'd1, {$urandom, $urandom, $urandom, $urandom}, 1'b1);
    // R2: index 4 clamped, narrow field
    run(1'b0, 3'd4, {$urandom, $urandom, $urandom, $urandom}, 1'b0);
    // R6: t=2 after t=8 leaves upper entries zero
    run(1'b1, 3'd0, {$urandom, $urandom, $urandom, $urandom}, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule